// File: doc/BRIEF.md
# Two-Wire Slave Address Recognition and Acknowledge Decision

This block sits beside the bit-level shifter of a two-wire serial bus controller. When the shifter has collected the first byte after a START, it presents that byte with a one-cycle address strobe. The block compares the upper seven bits against the device's own programmed address. It can also recognise the all-zero broadcast (general call) address when that is enabled. It reports which match occurred, gives the transfer direction for an own-address hit, raises an interrupt request and tells the shifter whether to pull SDA low in the ninth (acknowledge) bit.

For data bytes, a separate strobe asks for the acknowledge decision only. The block acknowledges a received data byte when the controller is receiving, in either master or slave role. A single acknowledge-enable input acts as a run-time disconnect. While it is low, no address is recognised and every byte is answered with a NACK. Recognition resumes as soon as the input returns high. The acknowledge value is produced entirely inside the block. The host has no path to read or force it.

Top module: `twi_addr_ack`

## Requirements
- R1: After reset the address register reads 0xFE; addr_match, gc_match, slv_tx, irq, ack_vld and ack_ok are all 0.
- R2: A cycle with addr_wr high loads addr_wdata into the address register, and the new value appears on addr_q after that edge. Bits 7..1 of the register hold the own 7-bit address, and bit 0 enables general-call recognition.
- R3: An addr_vld strobe whose byte has bits 7..1 equal to addr_q[7..1] while ack_en is high sets addr_match on the next edge. On that same edge, ack_vld and ack_ok are 1 and irq is 1 for exactly one cycle.
- R4: On an own-address match, slv_tx takes bit 0 of the received byte (1 = read, so the slave transmits). For any other address outcome, slv_tx is 0.
- R5: The received byte 0x00 sets gc_match and gives an ACK and an irq pulse only when addr_q[0] is 1. With addr_q[0] at 0, it gives a NACK and no irq.
- R6: The received byte 0x01 (broadcast address with the read bit set) is never matched and is answered with a NACK.
- R7: A seven-bit address of zero never produces addr_match, even when the own address is programmed to zero.
- R8: An address byte that is neither the own address nor a permitted general call clears both match flags, gives ack_vld=1 with ack_ok=0, and raises no irq.
- R9: While ack_en is low, address strobes produce no match, no irq and a NACK. Data strobes also produce a NACK. Recognition works again after ack_en returns high.
- R10: A data_vld strobe gives ack_vld=1 on the next edge, with ack_ok = ack_en AND rx_mode. It leaves the match flags unchanged and raises no irq.
- R11: When addr_vld and data_vld are high in the same cycle, the address decision is taken and the data strobe is ignored.
- R12: The match flags and slv_tx hold their value until the next addr_vld strobe. ack_vld and ack_ok are 1 only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Load strobe for the address register |
| addr_wdata | input | 8 | New address register value: own address in 7..1, general-call enable in 0 |
| addr_q | output | 8 | Current address register value |
| ack_en | input | 1 | Acknowledge enable; low disconnects the device from the bus |
| rx_mode | input | 1 | High while the controller is receiving data (master or slave) |
| rx_byte | input | 8 | Byte just collected from the bus |
| addr_vld | input | 1 | rx_byte is the address byte after a START |
| data_vld | input | 1 | rx_byte is a data byte |
| addr_match | output | 1 | Own address recognised |
| gc_match | output | 1 | General call recognised |
| slv_tx | output | 1 | Own address hit with the read bit set |
| irq | output | 1 | One-cycle interrupt request on an address match |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack_ok | output | 1 | 1 = drive ACK (SDA low), 0 = NACK (SDA released) |

## Verification
The bench targets the all-zero address from several sides. With the enable bit clear, a broadcast-gating error would acknowledge it. An own address of zero that is compared naively would report an own match on a broadcast. A broadcast with the read bit set would be acknowledged by a design that compares only seven bits. It also toggles ack_en around address and data strobes, where a design that missed the disconnect would still acknowledge. It drives both strobes together, where the wrong priority flips the acknowledge value. Finally it checks that the flags survive data strobes while irq and ack_vld drop after one cycle. A design with sticky or stretched pulses would show up there.

// File: rtl/twi_addr_ack.sv
module twi_addr_ack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_wr,
  input  logic [7:0] addr_wdata,
  output logic [7:0] addr_q,
  input  logic       ack_en,
  input  logic       rx_mode,
  input  logic [7:0] rx_byte,
  input  logic       addr_vld,
  input  logic       data_vld,
  output logic       addr_match,
  output logic       gc_match,
  output logic       slv_tx,
  output logic       irq,
  output logic       ack_vld,
  output logic       ack_ok
);

  logic [6:0] sla;
  logic       rw_bit;
  logic       own_hit;
  logic       gc_hit;

  assign sla     = rx_byte[7:1];
  assign rw_bit  = rx_byte[0];
  assign own_hit = ack_en && (sla != 7'd0) && (sla == addr_q[7:1]);
  assign gc_hit  = ack_en && addr_q[0] && (rx_byte == 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n)
      addr_q <= 8'hFE;
    else if (addr_wr)
      addr_q <= addr_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_match <= 1'b0;
      gc_match   <= 1'b0;
      slv_tx     <= 1'b0;
      irq        <= 1'b0;
      ack_vld    <= 1'b0;
      ack_ok     <= 1'b0;
    end else if (addr_vld) begin
      addr_match <= own_hit;
      gc_match   <= gc_hit;
      slv_tx     <= own_hit & rw_bit;
      irq        <= own_hit | gc_hit;
      ack_vld    <= 1'b1;
      ack_ok     <= own_hit | gc_hit;
    end else if (data_vld) begin
      irq        <= 1'b0;
      ack_vld    <= 1'b1;
      ack_ok     <= ack_en & rx_mode;
    end else begin
      irq        <= 1'b0;
      ack_vld    <= 1'b0;
      ack_ok     <= 1'b0;
    end
  end

  // R3
  irq_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (addr_match || gc_match));

  // R7
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_match, gc_match}));

  // R9
  disconnect_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_vld || data_vld) && !ack_en) |=> (ack_vld && !ack_ok && !irq));

  // R12
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_vld && !data_vld) |=> !ack_vld);

  // R12
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> ($stable(addr_match) && $stable(gc_match) && $stable(slv_tx)));

  // R10
  ack_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |-> ack_vld);

  // R4
  tx_only_on_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv_tx |-> addr_match);

endmodule

// File: tb/twi_addr_ack_tb.sv
module twi_addr_ack_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_wr = 1'b0;
  logic [7:0] addr_wdata = 8'h00;
  logic [7:0] addr_q;
  logic       ack_en = 1'b1;
  logic       rx_mode = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       addr_vld = 1'b0;
  logic       data_vld = 1'b0;
  logic       addr_match, gc_match, slv_tx, irq, ack_vld, ack_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  twi_addr_ack u_dut (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .addr_q(addr_q), .ack_en(ack_en), .rx_mode(rx_mode), .rx_byte(rx_byte),
    .addr_vld(addr_vld), .data_vld(data_vld), .addr_match(addr_match),
    .gc_match(gc_match), .slv_tx(slv_tx), .irq(irq), .ack_vld(ack_vld),
    .ack_ok(ack_ok)
  );

  // {own reg, ack_en, rx_byte, match, gc, slv_tx, ack}
  localparam logic [20:0] VEC [13] = '{
    {8'hA0, 1'b1, 8'hA0, 4'b1001},
    {8'hA0, 1'b1, 8'hA1, 4'b1011},
    {8'hA0, 1'b1, 8'hA2, 4'b0000},
    {8'hA1, 1'b1, 8'h00, 4'b0101},
    {8'hA0, 1'b1, 8'h00, 4'b0000},
    {8'hA1, 1'b1, 8'h01, 4'b0000},
    {8'h00, 1'b1, 8'h00, 4'b0000},
    {8'h01, 1'b1, 8'h00, 4'b0101},
    {8'h00, 1'b1, 8'h01, 4'b0000},
    {8'hA1, 1'b0, 8'hA0, 4'b0000},
    {8'hA1, 1'b0, 8'h00, 4'b0000},
    {8'hFE, 1'b1, 8'hFE, 4'b1001},
    {8'hFE, 1'b1, 8'hFF, 4'b1011}
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk); addr_wr = 1'b1; addr_wdata = v;
    @(negedge clk); addr_wr = 1'b0;
  endtask

  task automatic send(input logic a, input logic d, input logic [7:0] b);
    @(negedge clk); rx_byte = b; addr_vld = a; data_vld = d;
    @(negedge clk); addr_vld = 1'b0; data_vld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "addr_q", addr_q, 8'hFE);
    chk("R1", "flags", {2'b0, addr_match, gc_match, slv_tx, irq, ack_vld, ack_ok}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 register load
    write_reg(8'h5B);
    chk("R2", "addr_q", addr_q, 8'h5B);

    // R3 R4 R5 R6 R7 R8 R9 vector table
    for (int i = 0; i < 13; i++) begin
      write_reg(VEC[i][20:13]);
      ack_en = VEC[i][12];
      send(1'b1, 1'b0, VEC[i][11:4]);
      chk("R3-table", $sformatf("vec%0d match", i), {7'b0, addr_match}, {7'b0, VEC[i][3]});
      chk("R5-table", $sformatf("vec%0d gc", i), {7'b0, gc_match}, {7'b0, VEC[i][2]});
      chk("R4-table", $sformatf("vec%0d slv_tx", i), {7'b0, slv_tx}, {7'b0, VEC[i][1]});
      chk("R8-table", $sformatf("vec%0d ack", i), {6'b0, ack_vld, ack_ok}, {6'b0, 1'b1, VEC[i][0]});
      chk("R3-table", $sformatf("vec%0d irq", i), {7'b0, irq}, {7'b0, VEC[i][3] | VEC[i][2]});
      @(negedge clk);
      // R12 pulses drop, flags hold
      chk("R12", $sformatf("vec%0d pulses", i), {6'b0, irq, ack_vld}, 8'h00);
      chk("R12", $sformatf("vec%0d hold", i), {6'b0, addr_match, gc_match}, {6'b0, VEC[i][3], VEC[i][2]});
    end

    // R10 data strobe after an own match
    ack_en = 1'b1;
    write_reg(8'hA0);
    send(1'b1, 1'b0, 8'hA0);
    rx_mode = 1'b1;
    send(1'b0, 1'b1, 8'h3C);
    chk("R10", "rx ack", {5'b0, ack_vld, ack_ok, irq}, 8'b110);
    chk("R10", "flags kept", {6'b0, addr_match, gc_match}, 8'b10);
    rx_mode = 1'b0;
    send(1'b0, 1'b1, 8'h3C);
    chk("R10", "tx nack", {5'b0, ack_vld, ack_ok, irq}, 8'b100);

    // R9 disconnect for data, then restore recognition
    rx_mode = 1'b1;
    ack_en = 1'b0;
    send(1'b0, 1'b1, 8'h11);
    chk("R9", "data nack", {6'b0, ack_vld, ack_ok}, 8'b10);
    send(1'b1, 1'b0, 8'hA0);
    chk("R9", "addr off", {5'b0, addr_match, ack_ok, irq}, 8'b000);
    ack_en = 1'b1;
    send(1'b1, 1'b0, 8'hA0);
    chk("R9", "addr back", {5'b0, addr_match, ack_ok, irq}, 8'b111);

    // R11 both strobes: address decision wins
    rx_mode = 1'b1;
    send(1'b1, 1'b1, 8'hA2);
    chk("R11", "addr wins", {5'b0, ack_vld, ack_ok, addr_match}, 8'b100);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule